// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is the clocked front end of a small synchronous burst memory. Data is 36 bits wide, built from four 9-bit byte lanes, and the array depth is a parameter. At every rising clock edge the block samples three chip enables and two address-load strobes. The strobe on the processor side wins over the one on the controller side. It also samples a burst-advance input, a global write and a gated per-lane write enable. From these it decides whether the edge is a deselect, a new burst, a burst continuation or a burst suspension. A 2-bit burst counter walks the four words of an aligned group in either linear or interleaved order.

Reads are flow-through. After the edge that selects an address, the stored word appears on `rdata` in the same clock cycle, and no output register sits in between. The high-impedance output of a bus device is replaced here by a separate valid flag, `rvalid`. The flag is gated at once by the output-enable input, which is not clocked. A sleep input takes the block into a low-power state. Entering and leaving each take a fixed number of edges, and the block accepts no command while that is under way.

Top module: `sburst_sram_ctrl`

## Requirements
- R1: The chip is selected only when `en_a_n`=0, `en_b`=1 and `en_c_n`=0. A load edge (`pstb_n`=0 with `en_a_n`=0, or `cstb_n`=0) taken while the chip is not selected is a deselect: `rvalid` goes low and stays low until the next selected load.
- R2: `pstb_n`=0 together with `en_a_n`=0 on a selected chip starts a read burst at `addr`, whatever `cstb_n` is. The write inputs are ignored on that edge. A write asserted on the next edge, with no strobe and `adv_n`=1, stores into that same address.
- R3: `cstb_n`=0 with no processor load starts a burst at `addr`. The edge is a write when the write condition of R4 holds, and a read otherwise.
- R4: The write condition is `gw_n`=0, which writes all lanes, or `bwe_n`=0 with at least one `bw_n[k]`=0. Lane k covers data bits 9k to 9k+8. `bw_n` has no effect while `bwe_n`=1.
- R5: On an edge with no load, the chip enables are ignored. `adv_n`=0 moves to the next burst address and `adv_n`=1 keeps the current one. This holds for both reads and writes.
- R6: Only the two low address bits step. With `burst_ilv`=0 the order is start+n modulo 4. With `burst_ilv`=1 it is start XOR n. Upper bits stay fixed and the sequence wraps after four words.
- R7: After a read edge, `rdata` holds the array word at that edge's address in the same cycle. `rvalid` is 1 while `oe_n`=0, and it follows `oe_n` without a clock. `rdata` is 0 whenever `rvalid` is 0.
- R8: A write edge leaves `rvalid` low. A following suspend edge with no write (no load, `adv_n`=1) keeps it low. Only a load or an advance edge brings read data back.
- R9: `doze`=1 at an edge starts sleep entry. That edge and the next three are ignored and sleep is then reached. Once `doze`=0 in sleep, four more ignored edges follow before commands are accepted. `rvalid` is 0 all through, the array keeps its contents, and a new load is needed afterwards.
- R10: After reset `rvalid` is 0 and the chip counts as deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_a_n | input | 1 | Primary chip enable, active low |
| en_b | input | 1 | Second chip enable, active high |
| en_c_n | input | 1 | Third chip enable, active low |
| pstb_n | input | 1 | Processor-side address load strobe, active low |
| cstb_n | input | 1 | Controller-side address load strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, all lanes, active low |
| bwe_n | input | 1 | Lane write gate, active low |
| bw_n | input | 4 | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, not clocked, active low |
| doze | input | 1 | Sleep request, active high |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr | input | AW | Word address |
| wdata | input | 36 | Write data |
| rdata | output | 36 | Flow-through read data |
| rvalid | output | 1 | Read data valid (stands for a driven bus) |

## Verification
The bench fills bursts in one order and reads them back in the other. A counter that adds where it should XOR, or that carries into the upper bits, would return words from the wrong slots or break the wrap. One edge carries both strobes and a global write. There, a design that let the controller strobe win or that honoured the write would corrupt the word or hide the read data. Lane masks are checked with a pattern that alternates lanes, which exposes shifted or inverted lane mapping and writes taken while the gate is high. The sleep tests count edges exactly and attempt writes during the entry and exit windows. A design with a sleep sequence that was a cycle short would accept the read the bench places one edge too early.

// File: rtl/sburst_sram_ctrl.sv
module sburst_sram_ctrl #(
  parameter int AW          = 6,
  parameter int LANES       = 4,
  parameter int LANE_W      = 9,
  parameter int SLEEP_EDGES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_a_n,
  input  logic                    en_b,
  input  logic                    en_c_n,
  input  logic                    pstb_n,
  input  logic                    cstb_n,
  input  logic                    adv_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    oe_n,
  input  logic                    doze,
  input  logic                    burst_ilv,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);

  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << AW;
  localparam int SCW   = $clog2(SLEEP_EDGES + 1);

  typedef enum logic [2:0] {CY_NONE, CY_DESEL, CY_BEGIN, CY_CONT, CY_SUSP} cyc_t;
  typedef enum logic [1:0] {PS_AWAKE, PS_ENTER, PS_ASLEEP, PS_LEAVE} pwr_t;

  logic [DW-1:0]   mem [DEPTH];
  logic [AW-3:0]   hi_q;
  logic [1:0]      base_q, cnt_q;
  logic            act_q, rd_q;
  pwr_t            pst;
  logic [SCW-1:0]  scnt;
  cyc_t            cyc;
  logic [AW-1:0]   cur_addr, tgt_addr;

  function automatic logic [1:0] seq(input logic [1:0] b, input logic [1:0] n, input logic ilv);
    return ilv ? (b ^ n) : (b + n);
  endfunction

  wire chip_sel = !en_a_n && en_b && !en_c_n;
  wire cpu_go   = !en_a_n && !pstb_n;
  wire any_ld   = cpu_go || !cstb_n;
  wire [LANES-1:0] lane_hit = !gw_n ? {LANES{1'b1}} : (!bwe_n ? ~bw_n : {LANES{1'b0}});
  wire wr_req   = |lane_hit;
  wire awake    = (pst == PS_AWAKE);
  wire take     = awake && !doze;

  always_comb begin
    cyc = CY_NONE;
    if (take) begin
      if (any_ld)     cyc = chip_sel ? CY_BEGIN : CY_DESEL;
      else if (act_q) cyc = adv_n ? CY_SUSP : CY_CONT;
    end
  end

  wire is_wr = (cyc == CY_BEGIN) ? (!cpu_go && wr_req)
             : ((cyc == CY_CONT || cyc == CY_SUSP) && wr_req);

  assign cur_addr = {hi_q, seq(base_q, cnt_q, burst_ilv)};

  always_comb begin
    case (cyc)
      CY_BEGIN: tgt_addr = addr;
      CY_CONT:  tgt_addr = {hi_q, seq(base_q, cnt_q + 2'd1, burst_ilv)};
      default:  tgt_addr = cur_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (is_wr) begin
      for (int k = 0; k < LANES; k++)
        if (lane_hit[k]) mem[tgt_addr][k*LANE_W +: LANE_W] <= wdata[k*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      if (awake && doze) begin
        act_q <= 1'b0;
        rd_q  <= 1'b0;
      end
      case (cyc)
        CY_DESEL: begin
          act_q <= 1'b0;
          rd_q  <= 1'b0;
        end
        CY_BEGIN: begin
          act_q  <= 1'b1;
          rd_q   <= !is_wr;
          hi_q   <= addr[AW-1:2];
          base_q <= addr[1:0];
          cnt_q  <= 2'd0;
        end
        CY_CONT: begin
          rd_q  <= !is_wr;
          cnt_q <= cnt_q + 2'd1;
        end
        CY_SUSP: if (is_wr) rd_q <= 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pst  <= PS_AWAKE;
      scnt <= '0;
    end else begin
      case (pst)
        PS_AWAKE: if (doze) begin
          pst  <= PS_ENTER;
          scnt <= SCW'(1);
        end
        PS_ENTER: if (scnt == SCW'(SLEEP_EDGES - 1)) pst <= PS_ASLEEP;
                  else scnt <= scnt + SCW'(1);
        PS_ASLEEP: if (!doze) begin
          pst  <= PS_LEAVE;
          scnt <= SCW'(1);
        end
        PS_LEAVE: if (scnt == SCW'(SLEEP_EDGES - 1)) pst <= PS_AWAKE;
                  else scnt <= scnt + SCW'(1);
        default: pst <= PS_AWAKE;
      endcase
    end
  end

  assign rvalid = awake && act_q && rd_q && !oe_n;
  assign rdata  = rvalid ? mem[cur_addr] : '0;

  p_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CY_DESEL) |=> !rvalid);
  p_begin_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CY_BEGIN) |=> (cur_addr == $past(addr)));
  p_cpu_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CY_BEGIN && cpu_go && !oe_n) ##1 !oe_n |-> rvalid);
  p_susp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CY_SUSP) |=> $stable(cur_addr));
  p_cont_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CY_CONT) |=> (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])));
  p_write_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |=> !rvalid);
  p_sleep_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && doze) |=> !rvalid);

endmodule

// File: tb/sburst_sram_ctrl_tb.sv
`timescale 1ns/100ps
module sburst_sram_ctrl_tb;
  localparam int AW = 6;
  logic clk = 0, rst_n = 0;
  logic en_a_n, en_b, en_c_n, pstb_n, cstb_n, adv_n, gw_n, bwe_n, oe_n, doze, burst_ilv;
  logic [3:0] bw_n;
  logic [AW-1:0] addr;
  logic [35:0] wdata, rdata;
  logic rvalid;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sburst_sram_ctrl #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
    .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bw_n(bw_n), .oe_n(oe_n), .doze(doze), .burst_ilv(burst_ilv), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid));

  function automatic logic [35:0] pat(input int i);
    return {4{9'(i * 37 + 5)}};
  endfunction

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic enables(input logic a_n, input logic b, input logic c_n);
    en_a_n = a_n; en_b = b; en_c_n = c_n;
  endtask

  task automatic apply(input logic p_n, input logic c_n, input logic v_n, input logic g_n,
                       input logic be_n, input logic [3:0] b_n, input logic [AW-1:0] a,
                       input logic [35:0] d);
    @(negedge clk);
    pstb_n = p_n; cstb_n = c_n; adv_n = v_n; gw_n = g_n; bwe_n = be_n; bw_n = b_n;
    addr = a; wdata = d;
    @(posedge clk); #1;
  endtask

  task automatic wr_ctl(input logic [AW-1:0] a, input logic [35:0] d);
    apply(1, 0, 1, 0, 1, 4'hF, a, d);
  endtask
  task automatic rd_cpu(input logic [AW-1:0] a);
    apply(0, 1, 1, 1, 1, 4'hF, a, '0);
  endtask
  task automatic rd_next();
    apply(1, 1, 0, 1, 1, 4'hF, '0, '0);
  endtask

  task automatic t_reset();
    chk("R10 rvalid after reset", rvalid, 0);
  endtask

  task automatic t_linear();
    burst_ilv = 0;
    wr_ctl(6'h0A, pat(0));
    chk("R8 rvalid low after write", rvalid, 0);
    for (int k = 1; k < 4; k++) apply(1, 1, 0, 0, 1, 4'hF, '0, pat(k));
    rd_cpu(6'h08);
    chk("R7 valid on read", rvalid, 1);
    chk("R6 linear slot 0x08", rdata, pat(2));
    rd_next(); chk("R5 advance 0x09", rdata, pat(3));
    rd_next(); chk("R6 linear 0x0A", rdata, pat(0));
    rd_next(); chk("R6 linear 0x0B", rdata, pat(1));
    rd_next(); chk("R6 wrap to 0x08", rdata, pat(2));
  endtask

  task automatic t_interleave();
    burst_ilv = 1;
    wr_ctl(6'h11, pat(10));
    for (int k = 11; k < 14; k++) apply(1, 1, 0, 0, 1, 4'hF, '0, pat(k));
    burst_ilv = 0;
    rd_cpu(6'h10); chk("R6 ilv write 0x10", rdata, pat(11));
    rd_next();     chk("R6 ilv write 0x11", rdata, pat(10));
    rd_next();     chk("R6 ilv write 0x12", rdata, pat(13));
    rd_next();     chk("R6 ilv write 0x13", rdata, pat(12));
    burst_ilv = 1;
    rd_cpu(6'h12); chk("R6 ilv read 0x12", rdata, pat(13));
    rd_next();     chk("R6 ilv read 0x13", rdata, pat(12));
    rd_next();     chk("R6 ilv read 0x10", rdata, pat(11));
    burst_ilv = 0;
  endtask

  task automatic t_lanes();
    wr_ctl(6'h20, '1);
    apply(1, 0, 1, 1, 0, 4'b1010, 6'h20, '0);
    chk("R4 lane write hides output", rvalid, 0);
    apply(1, 0, 1, 1, 1, 4'b0000, 6'h20, '0);
    chk("R4 gate high means read", rvalid, 1);
    chk("R4 lanes 0,2 cleared", rdata, {9'h1FF, 9'h000, 9'h1FF, 9'h000});
    apply(1, 0, 1, 1, 0, 4'b1111, 6'h20, '0);
    chk("R3 no lane is read", rvalid, 1);
    chk("R4 data unchanged", rdata, {9'h1FF, 9'h000, 9'h1FF, 9'h000});
  endtask

  task automatic t_cpu_prec();
    wr_ctl(6'h21, pat(20));
    apply(0, 0, 1, 0, 1, 4'hF, 6'h21, pat(21));
    chk("R2 cpu strobe reads", rvalid, 1);
    chk("R2 write ignored on cpu edge", rdata, pat(20));
    apply(1, 1, 1, 0, 1, 4'hF, '0, pat(22));
    chk("R2 follow-up write quiet", rvalid, 0);
    rd_cpu(6'h21);
    chk("R2 follow-up write stored", rdata, pat(22));
  endtask

  task automatic t_select();
    rd_cpu(6'h21);
    chk("R1 selected read", rvalid, 1);
    enables(0, 0, 0);
    apply(1, 0, 1, 1, 1, 4'hF, 6'h21, '0);
    chk("R1 deselect en_b low", rvalid, 0);
    rd_next();
    chk("R1 stays deselected", rvalid, 0);
    enables(0, 1, 1);
    rd_cpu(6'h21);
    chk("R1 deselect en_c_n high", rvalid, 0);
    enables(0, 1, 0);
    rd_cpu(6'h08);
    chk("R1 reselect data", rdata, pat(2));
    enables(1, 1, 0);
    apply(0, 1, 1, 1, 1, 4'hF, 6'h20, '0);
    chk("R5 cpu strobe ignored, suspend", rdata, pat(2));
    enables(1, 0, 1);
    rd_next();
    chk("R5 enables ignored on advance", rdata, pat(3));
    enables(0, 1, 0);
  endtask

  task automatic t_oe();
    rd_cpu(6'h09);
    #0.5 oe_n = 1; #0.5;
    chk("R7 oe_n high drops valid", rvalid, 0);
    chk("R7 rdata zero when invalid", rdata, '0);
    oe_n = 0; #0.5;
    chk("R7 oe_n low restores data", rdata, pat(3));
  endtask

  task automatic t_susp_write();
    wr_ctl(6'h31, pat(31));
    wr_ctl(6'h30, pat(30));
    apply(1, 1, 1, 1, 1, 4'hF, '0, '0);
    chk("R8 suspend after write stays quiet", rvalid, 0);
    rd_next();
    chk("R8 advance restores valid", rvalid, 1);
    chk("R8 advance data", rdata, pat(31));
  endtask

  task automatic t_sleep();
    rd_cpu(6'h30);
    doze = 1;
    for (int k = 0; k < 7; k++) begin
      wr_ctl(6'h30, pat(40 + k));
      chk("R9 quiet while entering/asleep", rvalid, 0);
    end
    doze = 0;
    for (int k = 0; k < 4; k++) begin
      wr_ctl(6'h30, pat(50 + k));
      chk("R9 quiet while leaving", rvalid, 0);
    end
    rd_next();
    chk("R9 needs new load after wake", rvalid, 0);
    rd_cpu(6'h30);
    chk("R9 contents kept, writes ignored", rdata, pat(30));
    doze = 1;
    rd_cpu(6'h31);
    doze = 0;
    for (int k = 2; k <= 8; k++) begin
      rd_cpu(6'h31);
      chk("R9 edge within sleep window ignored", rvalid, 0);
    end
    rd_cpu(6'h31);
    chk("R9 ninth edge accepted", rdata, pat(31));
  endtask

  initial begin
    enables(0, 1, 0);
    pstb_n = 1; cstb_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = 4'hF;
    oe_n = 0; doze = 0; burst_ilv = 0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk) rst_n = 1;
    t_linear();
    t_interleave();
    t_lanes();
    t_cpu_prec();
    t_select();
    t_oe();
    t_susp_write();
    t_sleep();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule